// File: doc/BRIEF.md
# One-Wire OTP Programming Sequencer

This block is the byte-level slave side of the programming commands of a one-time-programmable store. It has a main data array made of 32-byte pages and an 8-byte status field. A line transceiver, which is outside this block, turns time slots into two events. `rx_vld` delivers a byte that the host wrote. `rd_req` asks the block for a byte the host wants to read, and the block answers on the next cycle. A separate input, `hv_present`, reports that the programming voltage is present on the line. CRC bytes use the polynomial x^8+x^5+x^4+1 and are shifted least-significant bit first. This is the reflected form with constant 8Ch.

A memory write takes a command, a start address of two bytes with the low byte first, and an 8-byte segment. Each of these phases is acknowledged by a CRC. After a program-control code and a qualified voltage pulse, the segment is ANDed into the array and then played back to the host. A status write programs one status byte per round. After each round the address advances, and the CRC register is preloaded with the low byte of the new address before the next data byte is shifted in. A line reset returns the block to command wait, except while a programming pulse is being counted or held.

Top module: `otp_prog_seq`

## Requirements
- R1: Command 0Fh, followed by an address low byte and an address high byte, makes the next read return the CRC (starting from 00h) of those three bytes. After that read the CRC register is cleared.
- R2: The eight bytes that follow go into the segment buffer in the order received. The next read returns the CRC of those eight bytes only.
- R3: After code 5Ah, the array becomes old AND buffer only if `hv_present` is sampled high on PROG_CYC consecutive clock edges. A shorter pulse leaves the array unchanged, and every later read returns FFh until a line reset.
- R4: Any code other than 5Ah at the program step leaves the array unchanged. Every later read returns FFh until a line reset.
- R5: After a memory programming pulse, eight reads return the array bytes from the start address upward in order. Every read after those returns FFh.
- R6: A memory start address is valid only if the high byte is 00h, the address is a multiple of 8 and it is below DATA_BYTES. With any other address the CRC of R1 is still returned, but the data is ignored and reads return FFh.
- R7: Command 55h, followed by address low, address high and one data byte, makes the next read return the CRC of those four bytes.
- R8: After a status programming pulse, a read returns the status byte after programming. The address then advances by one, and the next data byte's CRC starts from the new address low byte loaded into the register. Once byte 7 has been read back, reads return FFh.
- R9: Bit n (n = 0..3) of status byte 0 at 0 inhibits programming of data page n, which covers addresses n*32 to n*32+31. Readback still shows the unchanged contents.
- R10: Status bytes 0..6 start at FFh and can only lose bits. Status byte 7 always reads 00h.
- R11: A line reset during the wait for the voltage pulse aborts the write without programming. A line reset while the pulse is being counted or held is ignored.
- R12: In command wait, and after an unknown command, a read returns FFh. After chip reset `rd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous chip reset; erases the store |
| bus_rst | input | 1 | Line reset pulse seen by the transceiver |
| rx_vld | input | 1 | Host-written byte strobe |
| rx_data | input | 8 | Host-written byte |
| rd_req | input | 1 | Host read of one byte |
| rd_vld | output | 1 | Answer strobe, one cycle after rd_req |
| rd_data | output | 8 | Answer byte |
| hv_present | input | 1 | Programming voltage present |

## Verification
The bench builds the block with PROG_CYC = 20. This puts the exact pulse boundary within reach: 20 sampled cycles commit and 19 do not. It also makes room for many full program-and-readback rounds. The data array keeps its default of 128 bytes in four pages, so aligned, misaligned and out-of-range start addresses can all be tried, and write protection can be checked on one page while a neighbouring page still programs. A behavioural model holds the array, status bytes and CRCs in plain arrays and integers, and every answer strobe is compared on each clock.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

   localparam logic [7:0] CMD_WMEM  = 8'h0F;
   localparam logic [7:0] CMD_WSTAT = 8'h55;
   localparam logic [7:0] CODE_PROG = 8'h5A;
   localparam int         STAT_BYTES = 8;

   typedef enum logic [3:0] {
      S_IDLE, S_ALO, S_AHI, S_SDAT, S_CRCS, S_CRCA, S_MDAT, S_CRCD,
      S_CODE, S_PWAIT, S_PCNT, S_PHOLD, S_RBM, S_RBS, S_DEAD
   } seq_st_e;

   function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      logic       fb;
      r = c;
      for (int i = 0; i < 8; i++) begin
         fb = r[0] ^ d[i];
         r  = {1'b0, r[7:1]} ^ (fb ? 8'h8C : 8'h00);
      end
      return r;
   endfunction

endpackage

// File: rtl/otp_crc8.sv
module otp_crc8 import otp_seq_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic       sh,
   input  logic [7:0] din,
   output logic [7:0] crc
);
   logic [7:0] base;
   assign base = ld ? ld_val : crc;

   always_ff @(posedge clk) begin
      if (!rst_n)  crc <= 8'h00;
      else if (sh) crc <= crc8_step(base, din);
      else         crc <= base;
   end
endmodule

// File: rtl/otp_pulse_qual.sv
module otp_pulse_qual #(
   parameter int PROG_CYC = 625000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic vpp,
   output logic done
);
   localparam int CW = $clog2(PROG_CYC);
   localparam logic [CW-1:0] LAST = CW'(PROG_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en || !vpp) cnt_q <= '0;
      else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;
   end

   assign done = en && vpp && (cnt_q == LAST);

   p_done_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(vpp) && $past(en));
endmodule

// File: rtl/otp_store.sv
module otp_store import otp_seq_pkg::*; #(
   parameter int DATA_BYTES = 128,
   parameter int PAGE_BYTES = 32,
   parameter int SEG_BYTES  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_mem,
   input  logic                   wr_stat,
   input  logic [$clog2(DATA_BYTES)-1:0] addr,
   input  logic [2:0]             sidx,
   input  logic [SEG_BYTES*8-1:0] wbuf,
   output logic [7:0]             mem_rd,
   output logic [7:0]             stat_rd
);
   localparam int MAW = $clog2(DATA_BYTES);
   localparam int PAW = $clog2(PAGE_BYTES);
   localparam int SAW = $clog2(SEG_BYTES);

   logic [7:0] mem_q  [DATA_BYTES];
   logic [7:0] stat_q [STAT_BYTES-1];
   logic [7:0] prot_byte;
   logic       prot;

   assign prot_byte = stat_q[0];
   assign prot      = !prot_byte[addr[MAW-1:PAW]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DATA_BYTES; i++) mem_q[i] <= 8'hFF;
      end else if (wr_mem && !prot) begin
         for (int i = 0; i < DATA_BYTES; i++)
            if (addr[MAW-1:SAW] == (MAW-SAW)'(i / SEG_BYTES))
               mem_q[i] <= mem_q[i] & wbuf[(i % SEG_BYTES)*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAT_BYTES-1; i++) stat_q[i] <= 8'hFF;
      end else if (wr_stat) begin
         for (int i = 0; i < STAT_BYTES-1; i++)
            if (sidx == 3'(i)) stat_q[i] <= stat_q[i] & wbuf[7:0];
      end
   end

   assign mem_rd = mem_q[addr];

   always_comb begin
      stat_rd = 8'h00;
      for (int i = 0; i < STAT_BYTES-1; i++)
         if (sidx == 3'(i)) stat_rd = stat_q[i];
   end

   p_protect_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mem && prot) |=> $stable(mem_rd));

   for (genvar g = 0; g < STAT_BYTES-1; g++) begin : g_stat_chk
      p_stat_and_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[g] & ~$past(stat_q[g])) == 8'h00);
   end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq import otp_seq_pkg::*; #(
   parameter int DATA_BYTES = 128,
   parameter int PAGE_BYTES = 32,
   parameter int SEG_BYTES  = 8,
   parameter int PROG_CYC   = 625000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       rx_vld,
   input  logic [7:0] rx_data,
   input  logic       rd_req,
   output logic       rd_vld,
   output logic [7:0] rd_data,
   input  logic       hv_present
);
   localparam int MAW = $clog2(DATA_BYTES);
   localparam int SAW = $clog2(SEG_BYTES);

   if (DATA_BYTES > 256 || DATA_BYTES % PAGE_BYTES != 0 || DATA_BYTES / PAGE_BYTES > 4 ||
       DATA_BYTES / PAGE_BYTES < 2 || PAGE_BYTES % SEG_BYTES != 0 || SEG_BYTES < 2 ||
       (1 << SAW) != SEG_BYTES || (1 << $clog2(PAGE_BYTES)) != PAGE_BYTES || PROG_CYC < 2)
   begin : g_bad_params
      $error("otp_prog_seq: unsupported parameter combination");
   end

   seq_st_e               st_q;
   logic                  mode_stat_q, hi_bad_q;
   logic [7:0]            addr_q;
   logic [SAW-1:0]        cnt_q;
   logic [SEG_BYTES*8-1:0] buf_q;
   logic [7:0]            crc, crc_seed, mem_rd, stat_rd;
   logic                  crc_ld, crc_sh, done, wr_mem, wr_stat;
   logic                  rst_ok, last_cnt, mem_ok, stat_ok;

   assign rst_ok   = bus_rst && st_q != S_PCNT && st_q != S_PHOLD;
   assign last_cnt = cnt_q == SAW'(SEG_BYTES - 1);
   assign mem_ok   = !hi_bad_q && int'(addr_q) < DATA_BYTES && int'(addr_q) % SEG_BYTES == 0;
   assign stat_ok  = !hi_bad_q && int'(addr_q) < STAT_BYTES;
   assign wr_mem   = st_q == S_PCNT && done && !mode_stat_q;
   assign wr_stat  = st_q == S_PCNT && done &&  mode_stat_q;

   always_comb begin
      crc_ld = 1'b0; crc_sh = 1'b0; crc_seed = 8'h00;
      if (!rst_ok) begin
         case (st_q)
            S_IDLE: begin
               crc_ld = 1'b1;
               crc_sh = rx_vld && (rx_data == CMD_WMEM || rx_data == CMD_WSTAT);
            end
            S_ALO, S_AHI, S_SDAT, S_MDAT: crc_sh = rx_vld;
            S_CRCA: crc_ld = rd_req;
            S_RBS: begin crc_ld = rd_req; crc_seed = addr_q + 8'd1; end
            default: ;
         endcase
      end
   end

   otp_crc8 u_crc (
      .clk(clk), .rst_n(rst_n), .ld(crc_ld), .ld_val(crc_seed),
      .sh(crc_sh), .din(rx_data), .crc(crc)
   );

   otp_pulse_qual #(.PROG_CYC(PROG_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .en(st_q == S_PWAIT || st_q == S_PCNT),
      .vpp(hv_present), .done(done)
   );

   otp_store #(.DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES), .SEG_BYTES(SEG_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_mem(wr_mem), .wr_stat(wr_stat),
      .addr(addr_q[MAW-1:0]), .sidx(addr_q[2:0]), .wbuf(buf_q),
      .mem_rd(mem_rd), .stat_rd(stat_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= S_IDLE; mode_stat_q <= 1'b0; hi_bad_q <= 1'b0;
         addr_q <= 8'h00; cnt_q <= '0; buf_q <= '1;
      end else if (rst_ok) begin
         st_q <= S_IDLE; cnt_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (rx_vld) begin
               if (rx_data == CMD_WMEM)       begin mode_stat_q <= 1'b0; st_q <= S_ALO; end
               else if (rx_data == CMD_WSTAT) begin mode_stat_q <= 1'b1; st_q <= S_ALO; end
               else                           st_q <= S_DEAD;
            end
            S_ALO: if (rx_vld) begin addr_q <= rx_data; st_q <= S_AHI; end
            S_AHI: if (rx_vld) begin
               hi_bad_q <= rx_data != 8'h00;
               st_q     <= mode_stat_q ? S_SDAT : S_CRCA;
            end
            S_SDAT: if (rx_vld) begin buf_q[7:0] <= rx_data; st_q <= S_CRCS; end
            S_CRCS: if (rd_req) st_q <= stat_ok ? S_CODE : S_DEAD;
            S_CRCA: if (rd_req) begin cnt_q <= '0; st_q <= mem_ok ? S_MDAT : S_DEAD; end
            S_MDAT: if (rx_vld) begin
               buf_q[cnt_q*8 +: 8] <= rx_data;
               cnt_q <= cnt_q + 1'b1;
               if (last_cnt) st_q <= S_CRCD;
            end
            S_CRCD:  if (rd_req) st_q <= S_CODE;
            S_CODE:  if (rx_vld) st_q <= (rx_data == CODE_PROG) ? S_PWAIT : S_DEAD;
            S_PWAIT: if (hv_present) st_q <= S_PCNT;
            S_PCNT: begin
               if (done)             st_q <= S_PHOLD;
               else if (!hv_present) st_q <= S_DEAD;
            end
            S_PHOLD: if (!hv_present) begin
               cnt_q <= '0;
               st_q  <= mode_stat_q ? S_RBS : S_RBM;
            end
            S_RBM: if (rd_req) begin
               addr_q <= addr_q + 8'd1;
               cnt_q  <= cnt_q + 1'b1;
               if (last_cnt) st_q <= S_DEAD;
            end
            S_RBS: if (rd_req) begin
               if (addr_q == 8'(STAT_BYTES - 1)) st_q <= S_DEAD;
               else begin addr_q <= addr_q + 8'd1; st_q <= S_SDAT; end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld <= 1'b0; rd_data <= 8'hFF;
      end else begin
         rd_vld <= rd_req;
         if (rd_req) begin
            case (st_q)
               S_CRCA, S_CRCD, S_CRCS: rd_data <= crc;
               S_RBM:                  rd_data <= mem_rd;
               S_RBS:                  rd_data <= stat_rd;
               default:                rd_data <= 8'hFF;
            endcase
         end
      end
   end

   p_commit_under_vpp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mem || wr_stat) |-> hv_present && $past(hv_present));
   p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_mem, wr_stat}));
   p_hold_no_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_PHOLD && hv_present) |=> st_q == S_PHOLD);
   p_dead_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DEAD && rd_req) |=> (rd_vld && rd_data == 8'hFF));
   p_dead_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_DEAD) |=> (st_q == S_DEAD || st_q == S_IDLE));
   p_answer_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_vld);
endmodule

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;
   localparam int DB = 128, PB = 32, SB = 8, PC = 20;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, bus_rst = 1'b0, rx_vld = 1'b0, rd_req = 1'b0, hv_present = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic rd_vld;
   logic [7:0] rd_data;

   otp_prog_seq #(.DATA_BYTES(DB), .PAGE_BYTES(PB), .SEG_BYTES(SB), .PROG_CYC(PC)) dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_vld(rx_vld), .rx_data(rx_data),
      .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data), .hv_present(hv_present)
   );

   int checks = 0, fails = 0;
   logic [7:0] mem_m  [DB];
   logic [7:0] stat_m [8];
   logic req_d = 1'b0;

   function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r = c;
      for (int k = 0; k < 8; k++) begin
         if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 8'h8C;
         else                       r = r >> 1;
      end
      return r;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // every clock: answer strobe must follow exactly one cycle after a read request (R12)
   always @(posedge clk) req_d <= rst_n ? rd_req : 1'b0;
   always @(negedge clk) if (rst_n) check8("R12 answer strobe", {7'd0, rd_vld}, {7'd0, req_d});

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_vld = 1'b1; rx_data = b;
      @(negedge clk); rx_vld = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] exp, input string tag);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      check8(tag, rd_data, exp);
   endtask

   task automatic brst();
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic vpp_pulse(input int n);
      @(negedge clk); hv_present = 1'b1;
      repeat (n) @(negedge clk);
      hv_present = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wmem(input logic [7:0] a, input logic [63:0] d, input logic [7:0] code, input int plen);
      logic [7:0] c;
      bit prot;
      c = ref_crc(ref_crc(ref_crc(8'h00, 8'h0F), a), 8'h00);
      send(8'h0F); send(a); send(8'h00);
      rd_chk(c, "R1 address CRC");
      if (!(a < DB && a % SB == 0)) begin
         for (int i = 0; i < SB; i++) send(d[i*8 +: 8]);
         rd_chk(8'hFF, "R6 bad address ignored");
         send(8'h5A); vpp_pulse(PC);
         rd_chk(8'hFF, "R6 no readback");
         brst(); return;
      end
      c = 8'h00;
      for (int i = 0; i < SB; i++) begin send(d[i*8 +: 8]); c = ref_crc(c, d[i*8 +: 8]); end
      rd_chk(c, "R2 segment CRC");
      send(code);
      if (code != 8'h5A) begin
         vpp_pulse(PC); rd_chk(8'hFF, "R4 wrong code silent"); brst(); return;
      end
      vpp_pulse(plen);
      if (plen < PC) begin rd_chk(8'hFF, "R3 short pulse silent"); brst(); return; end
      prot = stat_m[0][a / PB] == 1'b0;
      if (!prot) for (int i = 0; i < SB; i++) mem_m[a + i] = mem_m[a + i] & d[i*8 +: 8];
      for (int i = 0; i < SB; i++)
         rd_chk(mem_m[a + i], prot ? "R9 protected page readback" : "R5 R3 segment readback");
      rd_chk(8'hFF, "R5 silent after segment");
      brst();
   endtask

   task automatic sround(input logic [7:0] a, input logic [7:0] d, input bit first);
      logic [7:0] c;
      if (first) begin
         c = ref_crc(ref_crc(ref_crc(8'h00, 8'h55), a), 8'h00);
         send(8'h55); send(a); send(8'h00);
      end else c = a;
      c = ref_crc(c, d);
      send(d);
      rd_chk(c, first ? "R7 status CRC" : "R8 follow-on status CRC");
      send(8'h5A); vpp_pulse(PC);
      if (a < 7) stat_m[a] = stat_m[a] & d;
      rd_chk((a == 7) ? 8'h00 : stat_m[a], (a == 7) ? "R10 byte 7 fixed" : "R8 status readback");
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] c;
      for (int i = 0; i < DB; i++) mem_m[i] = 8'hFF;
      for (int i = 0; i < 7; i++) stat_m[i] = 8'hFF;
      stat_m[7] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8("R12 reset strobe", {7'd0, rd_vld}, 8'h00);
      rd_chk(8'hFF, "R12 idle read");

      wmem(8'h08, 64'h0123_4567_89AB_CDEF, 8'h5A, PC);
      wmem(8'h08, 64'h0, 8'h5A, PC - 1);
      wmem(8'h08, 64'h0, 8'h5B, PC);
      wmem(8'h08, '1, 8'h5A, PC);
      wmem(8'h0C, 64'h0, 8'h5A, PC);
      wmem(8'h80, 64'h0, 8'h5A, PC);
      wmem(8'h78, 64'h1111_2222_3333_4444, 8'h5A, PC);
      wmem(8'h08, '1, 8'h5A, PC);

      // R11: reset before the pulse aborts
      c = ref_crc(ref_crc(ref_crc(8'h00, 8'h0F), 8'h10), 8'h00);
      send(8'h0F); send(8'h10); send(8'h00);
      rd_chk(c, "R11 address CRC");
      c = 8'h00;
      for (int i = 0; i < SB; i++) begin send(8'h00); c = ref_crc(c, 8'h00); end
      rd_chk(c, "R11 segment CRC");
      send(8'h5A); brst(); vpp_pulse(PC);
      wmem(8'h10, '1, 8'h5A, PC);

      // R11: reset during the counted pulse is ignored
      c = ref_crc(ref_crc(ref_crc(8'h00, 8'h0F), 8'h18), 8'h00);
      send(8'h0F); send(8'h18); send(8'h00);
      rd_chk(c, "R11 address CRC 2");
      c = 8'h00;
      for (int i = 0; i < SB; i++) begin send(8'(8'hA0 + i)); c = ref_crc(c, 8'(8'hA0 + i)); end
      rd_chk(c, "R11 segment CRC 2");
      send(8'h5A);
      @(negedge clk); hv_present = 1'b1;
      repeat (5) @(negedge clk);
      bus_rst = 1'b1; @(negedge clk); bus_rst = 1'b0;
      repeat (PC) @(negedge clk);
      hv_present = 1'b0;
      repeat (2) @(negedge clk);
      for (int i = 0; i < SB; i++) mem_m[8'h18 + i] = mem_m[8'h18 + i] & 8'(8'hA0 + i);
      for (int i = 0; i < SB; i++) rd_chk(mem_m[8'h18 + i], "R11 programmed despite reset");
      brst();

      sround(8'h00, 8'hFD, 1'b1);
      sround(8'h01, 8'h12, 1'b0);
      brst();
      wmem(8'h20, 64'h0, 8'h5A, PC);
      wmem(8'h00, 64'h5555_AAAA_0F0F_F0F0, 8'h5A, PC);
      wmem(8'h20, '1, 8'h5A, PC);

      sround(8'h06, 8'h0F, 1'b1);
      sround(8'h07, 8'hAA, 1'b0);
      rd_chk(8'hFF, "R8 silent after status end");
      brst();
      sround(8'h00, 8'hFF, 1'b1);
      brst();

      send(8'h33);
      rd_chk(8'hFF, "R12 unknown command");
      brst();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule